// File: doc/BRIEF.md
# Trigger Timestamp Unit

This block marks each accepted trigger with its time position. A 64-bit time base advances in the sample domain. At a trigger, the block takes the value the time base holds in that cycle, packs it into a 128-bit record and queues the record for a downstream consumer. Three time-base behaviours can be selected. In free mode the count runs until software clears it. In start-cleared mode an acquisition-start pulse also zeroes it. In split mode the count is two fields: a 24-bit count of external reference pulses, such as a once-per-second signal, and a 40-bit count of samples that restarts at each reference pulse.

The reference input may arrive from any clock domain. It passes through a two-flop synchroniser and a rising-edge detector before it touches the count. Two auxiliary input bits can be latched with the stamp at trigger time. Records leave on a valid/ready stream fed by a small FIFO. The consumer may hold `rec_ready` low for as long as it likes. While `rec_valid` is high and `rec_ready` is low, the head record stays on `rec_data` unchanged. When the FIFO has no room, new triggers are discarded and a sticky flag reports the loss.

Top module: `trigger_timestamp`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rec_valid` and `overflow` are 0 and the time base is 0. The reset is asynchronous and active low.
- R2: With `mode_sel` equal to 0 or 3 (free mode), the 64-bit time base advances by one at each clock edge where `smp_en` is 1. At an edge where `smp_en` is 0, it holds its value.
- R3: A `cnt_clear` high at a clock edge sets the whole time base to 0 at that edge, in every mode. It takes precedence over counting, over start clearing and over reference pulses.
- R4: With `mode_sel` equal to 1 (start-cleared mode), an `acq_start` high at an edge zeroes the time base. In the other modes `acq_start` has no effect.
- R5: With `mode_sel` equal to 2 (split mode), bits 63:40 count reference pulses and bits 39:0 count `smp_en` edges, wrapping without carry into the upper field. If `ref_in` is first sampled high at edge k, then at edge k+2 the upper field increments and the lower field becomes 0, whatever `smp_en` is. A level held high counts as one pulse.
- R6: A `trig_in` high at an edge stores a record whose bits 63:0 equal the time-base value present in that cycle, before that edge updates it. Triggers in consecutive cycles each produce their own record.
- R7: Record bits 65:64 hold `aux_in` sampled at the trigger edge when `aux_en` is 1, and hold 0 when `aux_en` is 0. Bits 127:66 are always 0.
- R8: `rec_valid` is 1 exactly when at least one record is queued. A record transfers at an edge where `rec_valid` and `rec_ready` are both 1. Records leave in trigger order. While `rec_valid` is 1 and `rec_ready` is 0, `rec_data` holds steady.
- R9: A trigger that finds the FIFO full, with no transfer at the same edge, is dropped and sets `overflow`. `overflow` then stays 1 until reset. A trigger that arrives while the FIFO is full and the head is transferring in the same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample-clock enable; advances the time base |
| trig_in | input | 1 | Trigger pulse, one record per high cycle |
| acq_start | input | 1 | Acquisition-start pulse, clears the time base in mode 1 |
| cnt_clear | input | 1 | Manual clear of the time base |
| ref_in | input | 1 | Asynchronous reference pulse input |
| aux_in | input | 2 | Auxiliary bits latched at trigger time |
| aux_en | input | 1 | Store `aux_in` in the record when 1 |
| mode_sel | input | 2 | 0/3 free, 1 start-cleared, 2 split reference mode |
| rec_valid | output | 1 | A record is presented |
| rec_ready | input | 1 | Consumer accepts the presented record |
| rec_data | output | 128 | Record: stamp 63:0, aux 65:64, zero above |
| overflow | output | 1 | Sticky: a record was dropped |

## Verification
Several corner cases are targeted.
- Triggers in consecutive cycles must carry stamps exactly one apart. A design that stamped after the update would be one sample late throughout.
- A clear or start pulse in the same cycle as a trigger must leave the pre-clear value in the record.
- In split mode, a reference level held high for many cycles must advance the upper field only once, and the two-edge synchroniser latency must be exact. A missing edge detector would keep the lower field pinned at zero, and a wrong latency shifts every stamp that follows the pulse.
- The queue is filled under back-pressure. Further triggers are then driven both without a pop and together with one. A design that refused the simultaneous push and pop would lose a record, and one that overwrote the head would corrupt the ordered output stream.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    TS_FREE    = 2'd0,
    TS_ONSTART = 2'd1,
    TS_SPLIT   = 2'd2,
    TS_ALT     = 2'd3
  } ts_mode_e;

  localparam int STAMP_HI_W = 24;
  localparam int STAMP_LO_W = 40;
  localparam int STAMP_W    = STAMP_HI_W + STAMP_LO_W;
  localparam int AUX_W      = 2;
  localparam int REC_W      = 128;
  localparam int PAD_W      = REC_W - STAMP_W - AUX_W;
endpackage

// File: rtl/ts_ref_sync.sv
module ts_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic ref_rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], ref_async};
  end

  // newest synchronised level high, previous one low
  assign ref_rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ts_counter.sv
module ts_counter
  import ts_pkg::*;
#(
  parameter int HI_W = STAMP_HI_W,
  parameter int LO_W = STAMP_LO_W,
  localparam int TW = HI_W + LO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          clr,
  input  logic          start,
  input  ts_mode_e      mode,
  input  logic          ref_rise,
  output logic [TW-1:0] stamp
);
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;

  assign hi_q = stamp[TW-1:LO_W];
  assign lo_q = stamp[LO_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp <= '0;
    end else if (clr) begin
      stamp <= '0;
    end else if (mode == TS_ONSTART && start) begin
      stamp <= '0;
    end else if (mode == TS_SPLIT) begin
      if (ref_rise)    stamp <= {hi_q + 1'b1, {LO_W{1'b0}}};
      else if (smp_en) stamp <= {hi_q, lo_q + 1'b1};
    end else if (smp_en) begin
      stamp <= stamp + 1'b1;
    end
  end
endmodule

// File: rtl/ts_fifo.sv
module ts_fifo #(
  parameter int W     = 128,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          not_empty,
  output logic [CW-1:0] fill
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      unique case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign dout      = mem[rp];
  assign not_empty = (fill != '0);
endmodule

// File: rtl/trigger_timestamp.sv
module trigger_timestamp
  import ts_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              trig_in,
  input  logic              acq_start,
  input  logic              cnt_clear,
  input  logic              ref_in,
  input  logic [AUX_W-1:0]  aux_in,
  input  logic              aux_en,
  input  logic [1:0]        mode_sel,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [REC_W-1:0]  rec_data,
  output logic              overflow
);
  logic               ref_rise;
  logic [STAMP_W-1:0] stamp_now;
  logic [FILL_W-1:0]  fifo_cnt;
  logic               pop, room, push;
  logic [REC_W-1:0]   rec_new;
  logic [AUX_W-1:0]   aux_kept;

  ts_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_async (ref_in),
    .ref_rise  (ref_rise)
  );

  ts_counter #(.HI_W(STAMP_HI_W), .LO_W(STAMP_LO_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en   (smp_en),
    .clr      (cnt_clear),
    .start    (acq_start),
    .mode     (ts_mode_e'(mode_sel)),
    .ref_rise (ref_rise),
    .stamp    (stamp_now)
  );

  assign aux_kept = aux_en ? aux_in : '0;
  assign rec_new  = {{PAD_W{1'b0}}, aux_kept, stamp_now};
  assign pop      = rec_valid & rec_ready;
  assign room     = (fifo_cnt != FILL_W'(DEPTH)) | pop;
  assign push     = trig_in & room;

  ts_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .din       (rec_new),
    .pop       (pop),
    .dout      (rec_data),
    .not_empty (rec_valid),
    .fill      (fifo_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              overflow <= 1'b0;
    else if (trig_in & !room) overflow <= 1'b1;
  end
endmodule

// File: rtl/ts_checker.sv
module ts_checker #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig_in,
  input logic          smp_en,
  input logic          cnt_clear,
  input logic          acq_start,
  input logic [1:0]    mode_sel,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [127:0]  rec_data,
  input logic          overflow,
  input logic [CW-1:0] fill,
  input logic [63:0]   stamp
);
  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rec_valid && !overflow && stamp == 64'd0));

  // R2
  free_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !cnt_clear && (mode_sel == 2'd0 || mode_sel == 2'd3))
      |=> stamp == $past(stamp) + 64'd1);

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> stamp == 64'd0);

  // R4
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd1 && acq_start) |=> stamp == 64'd0);

  // R7
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_data[127:66] == '0);

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data)));

  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && fill == CW'(DEPTH) && !(rec_valid && rec_ready)) |=> overflow);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind trigger_timestamp ts_checker #(.DEPTH(DEPTH), .CW(FILL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_in   (trig_in),
  .smp_en    (smp_en),
  .cnt_clear (cnt_clear),
  .acq_start (acq_start),
  .mode_sel  (mode_sel),
  .rec_valid (rec_valid),
  .rec_ready (rec_ready),
  .rec_data  (rec_data),
  .overflow  (overflow),
  .fill      (fifo_cnt),
  .stamp     (stamp_now)
);

// File: tb/trigger_timestamp_bench.sv
`timescale 1ns/1ps
module trigger_timestamp_bench;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0, trig_in = 1'b0, acq_start = 1'b0, cnt_clear = 1'b0;
  logic ref_in = 1'b0, aux_en = 1'b0, rec_ready = 1'b0;
  logic [1:0] aux_in = 2'b00;
  logic [1:0] mode_sel = 2'd0;
  logic rec_valid, overflow;
  logic [127:0] rec_data;

  int checks = 0;
  int fails = 0;
  string cur = "R1";

  // behavioural reference state
  logic [127:0] q[$];
  logic [63:0]  m_cnt;
  logic         m_ovf;
  logic         m_r1, m_r2, m_r3;

  always #2.5 clk = ~clk;

  trigger_timestamp #(.DEPTH(DEPTH)) u_trigger_timestamp (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .trig_in(trig_in),
    .acq_start(acq_start), .cnt_clear(cnt_clear), .ref_in(ref_in),
    .aux_in(aux_in), .aux_en(aux_en), .mode_sel(mode_sel),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic pop, rise;
    int   room;
    if (!rst_n) begin
      q.delete();
      m_cnt = '0; m_ovf = 1'b0;
      m_r1 = 1'b0; m_r2 = 1'b0; m_r3 = 1'b0;
      return;
    end
    pop  = (q.size() > 0) && rec_ready;
    rise = m_r2 && !m_r3;
    room = DEPTH - q.size() + (pop ? 1 : 0);
    if (pop) void'(q.pop_front());
    if (trig_in) begin
      if (room > 0) q.push_back({62'd0, (aux_en ? aux_in : 2'b00), m_cnt});
      else          m_ovf = 1'b1;
    end
    if (cnt_clear)                         m_cnt = '0;
    else if (mode_sel == 2'd1 && acq_start) m_cnt = '0;
    else if (mode_sel == 2'd2) begin
      if (rise)        m_cnt = {m_cnt[63:40] + 24'd1, 40'd0};
      else if (smp_en) m_cnt = {m_cnt[63:40], m_cnt[39:0] + 40'd1};
    end else if (smp_en) m_cnt = m_cnt + 64'd1;
    m_r3 = m_r2; m_r2 = m_r1; m_r1 = ref_in;
  endtask

  task automatic compare();
    check(rec_valid == (q.size() > 0), {cur, " valid"}, 128'(rec_valid), 128'(q.size() > 0));
    check(overflow == m_ovf, {cur, " overflow"}, 128'(overflow), 128'(m_ovf));
    if (q.size() > 0) check(rec_data == q[0], {cur, " record"}, rec_data, q[0]);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n, input int trig_pct, input int en_pct, input int rdy_pct);
    for (int i = 0; i < n; i++) begin
      trig_in   = ($urandom_range(99) < trig_pct);
      smp_en    = ($urandom_range(99) < en_pct);
      rec_ready = ($urandom_range(99) < rdy_pct);
      aux_in    = 2'($urandom_range(3));
      tick();
    end
    trig_in = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    cur = "R1";
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1'b1;
    tick();
    trig_in = 1'b1; rec_ready = 1'b0;
    tick();
    trig_in = 1'b0;
    check(rec_data[63:0] == 64'd0, "R1 first stamp", rec_data, 128'd0);
    rec_ready = 1'b1; tick();

    // R2 free mode, modes 0 and 3
    cur = "R2"; mode_sel = 2'd0;
    run(40, 30, 60, 100);
    mode_sel = 2'd3;
    run(30, 30, 60, 100);

    // R6 back-to-back triggers
    cur = "R6"; mode_sel = 2'd0;
    run(10, 100, 100, 100);
    run(6, 0, 0, 100);

    // R3 clears in free and split modes, with trigger in the same cycle
    cur = "R3";
    for (int m = 0; m < 3; m++) begin
      mode_sel = 2'(m);
      run(5, 0, 100, 100);
      cnt_clear = 1'b1; trig_in = 1'b1; smp_en = 1'b1; ref_in = (m == 2);
      tick();
      cnt_clear = 1'b0;
      run(6, 50, 100, 100);
      ref_in = 1'b0;
    end

    // R4 start-cleared mode, then start ignored in other modes
    cur = "R4";
    for (int m = 0; m < 4; m++) begin
      mode_sel = 2'(m);
      run(6, 0, 100, 100);
      acq_start = 1'b1; trig_in = 1'b1; smp_en = 1'b1;
      tick();
      acq_start = 1'b0;
      run(4, 100, 100, 100);
    end

    // R5 split reference mode
    cur = "R5"; mode_sel = 2'd2;
    cnt_clear = 1'b1; tick(); cnt_clear = 1'b0;
    for (int i = 0; i < 90; i++) begin
      ref_in    = (i == 5) || (i >= 15 && i < 18) || (i >= 30 && i < 60) || (i == 70);
      trig_in   = ($urandom_range(99) < 50);
      smp_en    = ($urandom_range(99) < 70);
      rec_ready = 1'b1;
      tick();
    end
    ref_in = 1'b0; trig_in = 1'b0;
    run(8, 0, 50, 100);

    // R7 auxiliary capture on and off
    cur = "R7"; mode_sel = 2'd0;
    aux_en = 1'b1; run(20, 60, 50, 100);
    aux_en = 1'b0; run(20, 60, 50, 100);
    aux_en = 1'b1;

    // R8 random back-pressure
    cur = "R8";
    run(60, 30, 50, 50);
    run(10, 0, 50, 100);

    // R9 fill, drop, then push during pop at full
    cur = "R9";
    rec_ready = 1'b0; smp_en = 1'b1;
    for (int i = 0; i < DEPTH + 3; i++) begin trig_in = 1'b1; aux_in = 2'(i); tick(); end
    rec_ready = 1'b1; trig_in = 1'b1; tick();
    trig_in = 1'b0; rec_ready = 1'b0; tick();
    rec_ready = 1'b1;
    run(DEPTH + 3, 0, 100, 100);

    // R1 reset again clears the sticky flag
    cur = "R1";
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    check(overflow == 1'b0, "R1 overflow after reset", 128'(overflow), 128'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule